// File: doc/BRIEF.md
# DMA Channel Request and Mode Controller

This block is the control logic of one DMA channel. It decides when the channel asks a bus interface to move one transfer unit. It also counts the remaining units, flags the end of the transfer and raises an end-of-transfer interrupt. A request can come from three sources:

- an external request pin, sampled in one of four detection modes;
- an on-chip peripheral request line;
- an internal auto-request.

Requests go to the bus as a per-unit req/ack handshake. In cycle-steal mode the channel drops its request after every unit. In burst mode it keeps the request up until the count is exhausted.

Software programs the channel through a two-address write port. Address 0 is the control word and address 1 is the unit count. Software observes the channel through three outputs: the remaining count, the end flag and the interrupt. The channel index is a parameter. Only the low-numbered channels honour the pin detection select; the others always detect an active-low level.

Top module: `dmach_top`

## Requirements
- R1: After reset the control word is all zero (disabled, interrupt off, cycle-steal, active-low detection, external source), the count is 0, and `te_o`, `irq_o` and `bus_req_o` are 0.
- R2: A write to address 1 loads the count from `wr_data_i`. A write to address 0 loads the control word with these fields:
  - bit 0: enable;
  - bit 1: interrupt enable;
  - bit 2: burst;
  - bits 4:3: detection select;
  - bits 6:5: source (00 external pin, 01 peripheral, 10 auto, 11 none);
  - bit 7: end-flag keep bit.
- R3: Detection select 00 requests while the synchronized pin is low and 10 requests while it is high. 01 latches one pending request per falling edge and 11 latches one per rising edge, and the pending request stays until its unit is acknowledged.
- R4: The detection select has no effect for peripheral or auto sources. A channel with `CHAN_ID >= NUM_DET_CH` always uses active-low level detection, whatever value is written.
- R5: In cycle-steal mode `bus_req_o` falls in the cycle after every acknowledged unit, so each unit has its own request.
- R6: In burst mode, once `bus_req_o` rises it stays high until the unit that brings the count to zero is acknowledged.
- R7: With the peripheral source the channel runs as cycle-steal even when the burst bit is 1.
- R8: The auto source requests continuously while the channel is enabled and the count is nonzero. With enable 0, or with a count of 0, no request is made.
- R9: The count decrements by one only for a unit acknowledged while `bus_req_o` is high. `bus_ack_i` has no effect while `bus_req_o` is low.
- R10: `te_o` sets when an acknowledged unit brings the count to zero. It stays set until a control write with bit 7 = 0. A control write with bit 7 = 1 leaves it unchanged.
- R11: `irq_o` equals `te_o` AND the interrupt enable bit. It follows later changes of either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 control, 1 count |
| wr_data_i | input | DATA_W | Write data |
| dreq_i | input | 1 | External request pin (asynchronous) |
| periph_req_i | input | 1 | On-chip peripheral request level |
| bus_req_o | output | 1 | Unit transfer request to the bus interface |
| bus_ack_i | input | 1 | Unit acknowledge from the bus interface |
| cnt_o | output | CNT_W | Remaining unit count |
| te_o | output | 1 | Transfer-end flag |
| irq_o | output | 1 | End-of-transfer interrupt request |

## Verification
The request path is driven with constant auto requests and with held pin levels. It is also driven with trains of pin pulses, and with peripheral levels, in both bus modes. The number of acknowledged units separates level detection from edge detection and an active level from an inactive one. The number of request rising edges separates cycle-steal from burst, including the forced cycle-steal of the peripheral source. Separate runs check the following:
- pin levels that should be ignored under the peripheral and auto sources and on a high-numbered channel, looked at through the remaining count;
- a stray acknowledge while idle;
- the keep/clear behaviour of the end flag against the interrupt enable.

// File: rtl/dmach_pkg.sv
`timescale 1ns/1ps
package dmach_pkg;
  typedef enum logic [1:0] {
    SRC_EXT    = 2'b00,
    SRC_PERIPH = 2'b01,
    SRC_AUTO   = 2'b10,
    SRC_NONE   = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_FALL = 2'b01,
    DET_HIGH = 2'b10,
    DET_RISE = 2'b11
  } det_e;

  typedef struct packed {
    src_e src;
    det_e det;
    logic burst;
    logic ie;
    logic en;
  } ctrl_t;

  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_IE    = 1;
  localparam int unsigned BIT_BURST = 2;
  localparam int unsigned BIT_DET   = 3;
  localparam int unsigned BIT_SRC   = 5;
  localparam int unsigned BIT_KEEP  = 7;
  localparam int unsigned CTRL_W    = 8;
endpackage

// File: rtl/dmach_ctrl_reg.sv
`timescale 1ns/1ps
module dmach_ctrl_reg import dmach_pkg::*; #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned CHAN_ID    = 0,
  parameter int unsigned NUM_DET_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o,
  output logic              cnt_load_o,
  output logic [CNT_W-1:0]  cnt_val_o,
  output logic              te_clr_o
);
  localparam bit DET_OK = (CHAN_ID < NUM_DET_CH);

  logic ctrl_wr;
  logic en_q, ie_q, burst_q;
  src_e src_q;

  assign ctrl_wr    = wr_en_i && (wr_addr_i == 1'b0);
  assign cnt_load_o = wr_en_i && (wr_addr_i == 1'b1);
  assign cnt_val_o  = wr_data_i[CNT_W-1:0];
  assign te_clr_o   = ctrl_wr && !wr_data_i[BIT_KEEP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      burst_q <= 1'b0;
      src_q   <= SRC_EXT;
    end else if (ctrl_wr) begin
      en_q    <= wr_data_i[BIT_EN];
      ie_q    <= wr_data_i[BIT_IE];
      burst_q <= wr_data_i[BIT_BURST];
      src_q   <= src_e'(wr_data_i[BIT_SRC+:2]);
    end
  end

  // detection select exists only on low-numbered channels
  generate
    if (DET_OK) begin : g_det
      det_e det_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      det_q <= DET_LOW;
        else if (ctrl_wr) det_q <= det_e'(wr_data_i[BIT_DET+:2]);
      end
      assign ctrl_o.det = det_q;
    end else begin : g_fixed
      assign ctrl_o.det = DET_LOW;
    end
  endgenerate

  assign ctrl_o.src   = src_q;
  assign ctrl_o.burst = burst_q;
  assign ctrl_o.ie    = ie_q;
  assign ctrl_o.en    = en_q;
endmodule

// File: rtl/dmach_dreq_det.sv
`timescale 1ns/1ps
module dmach_dreq_det import dmach_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dreq_i,
  input  det_e mode_i,
  input  logic en_i,
  input  logic ack_i,
  output logic req_o
);
  logic sync1_q, sync2_q, prev_q, pend_q;
  logic edge_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= dreq_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    unique case (mode_i)
      DET_FALL: edge_hit = prev_q && !sync2_q;
      DET_RISE: edge_hit = !prev_q && sync2_q;
      default:  edge_hit = 1'b0;
    endcase
  end

  // new edge wins over the acknowledge of the previous one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (!en_i)    pend_q <= 1'b0;
    else if (edge_hit) pend_q <= 1'b1;
    else if (ack_i)    pend_q <= 1'b0;
  end

  always_comb begin
    unique case (mode_i)
      DET_LOW:  req_o = en_i && !sync2_q;
      DET_HIGH: req_o = en_i && sync2_q;
      default:  req_o = en_i && pend_q;
    endcase
  end

  // R3
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !ack_i && en_i |=> pend_q);
endmodule

// File: rtl/dmach_counter.sv
`timescale 1ns/1ps
module dmach_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             fire_i,
  input  logic             te_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             te_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             te_q;
  logic             nz, last;

  assign nz   = (cnt_q != '0);
  assign last = (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (fire_i && nz) cnt_q <= cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      te_q <= 1'b0;
    else if (fire_i && last && !load_i) te_q <= 1'b1;
    else if (te_clr_i)                te_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign te_o  = te_q;

  // R9
  cnt_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !fire_i |=> $stable(cnt_q));
  // R10
  te_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    te_q && !te_clr_i |=> te_q);
  // R10
  te_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(te_q) |-> $past(fire_i) && (cnt_q == '0));
endmodule

// File: rtl/dmach_req_fsm.sv
`timescale 1ns/1ps
module dmach_req_fsm import dmach_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ext_req_i,
  input  logic             periph_req_i,
  input  logic             bus_ack_i,
  output logic             bus_req_o,
  output logic             fire_o
);
  typedef enum logic {ST_IDLE, ST_REQ} st_e;

  st_e  st_q, st_d;
  logic want, eff_burst, active, last_unit;

  always_comb begin
    unique case (ctrl_i.src)
      SRC_EXT:    want = ext_req_i;
      SRC_PERIPH: want = periph_req_i;
      SRC_AUTO:   want = 1'b1;
      default:    want = 1'b0;
    endcase
  end

  assign eff_burst = ctrl_i.burst && (ctrl_i.src != SRC_PERIPH);
  assign active    = ctrl_i.en && (cnt_i != '0);
  assign last_unit = (cnt_i == CNT_W'(1));
  assign bus_req_o = (st_q == ST_REQ);
  assign fire_o    = bus_req_o && bus_ack_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (active && want) st_d = ST_REQ;
      ST_REQ: begin
        if (!active) st_d = ST_IDLE;
        else if (fire_o && (!eff_burst || last_unit)) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // R5
  cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && !eff_burst |=> !bus_req_o);
  // R6
  burst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && eff_burst && active && !(fire_o && last_unit) |=> bus_req_o);
  // R7
  periph_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && (ctrl_i.src == SRC_PERIPH) |=> !bus_req_o);
  // R8
  no_idle_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.en |=> !$rose(bus_req_o));
endmodule

// File: rtl/dmach_top.sv
`timescale 1ns/1ps
module dmach_top import dmach_pkg::*; #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned CHAN_ID    = 0,
  parameter int unsigned NUM_DET_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              dreq_i,
  input  logic              periph_req_i,
  output logic              bus_req_o,
  input  logic              bus_ack_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              te_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic             cnt_load, te_clr, fire, ext_req, det_en;
  logic [CNT_W-1:0] cnt_val;

  dmach_ctrl_reg #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .CHAN_ID(CHAN_ID), .NUM_DET_CH(NUM_DET_CH)
  ) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .cnt_load_o(cnt_load), .cnt_val_o(cnt_val), .te_clr_o(te_clr)
  );

  assign det_en = ctrl.en && (ctrl.src == SRC_EXT);

  dmach_dreq_det u_det (
    .clk_i, .rst_ni, .dreq_i, .mode_i(ctrl.det), .en_i(det_en),
    .ack_i(fire), .req_o(ext_req)
  );

  dmach_req_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .cnt_i(cnt_o), .ext_req_i(ext_req),
    .periph_req_i, .bus_ack_i, .bus_req_o, .fire_o(fire)
  );

  dmach_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(cnt_load), .load_val_i(cnt_val), .fire_i(fire),
    .te_clr_i(te_clr), .cnt_o, .te_o
  );

  assign irq_o = te_o && ctrl.ie;

  // R11
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(te_o) |-> !irq_o);
endmodule

// File: tb/dmach_top_tb_top.sv
`timescale 1ns/1ps
module dmach_top_tb_top;
  localparam int unsigned DW = 16;
  localparam int unsigned CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0, wr_addr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          dreq = 1'b0, periph_req = 1'b0;
  logic          bus_req, bus_ack = 1'b0, te, irq;
  logic [CW-1:0] cnt;
  logic          hi_req, hi_ack = 1'b0, hi_te, hi_irq;
  logic [CW-1:0] hi_cnt;

  always #2.5 clk_i = ~clk_i;

  dmach_top #(.DATA_W(DW), .CNT_W(CW), .CHAN_ID(0)) dut_i (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .dreq_i(dreq), .periph_req_i(periph_req), .bus_req_o(bus_req),
    .bus_ack_i(bus_ack), .cnt_o(cnt), .te_o(te), .irq_o(irq)
  );

  dmach_top #(.DATA_W(DW), .CNT_W(CW), .CHAN_ID(5)) dut_hi_i (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .dreq_i(dreq), .periph_req_i(periph_req), .bus_req_o(hi_req),
    .bus_ack_i(hi_ack), .cnt_o(hi_cnt), .te_o(hi_te), .irq_o(hi_irq)
  );

  int checks = 0, errors = 0, units = 0, rises = 0;
  logic last_req = 1'b0, ack_force = 1'b0;
  bit done = 0;

  // bus stub: acknowledge each request half a cycle after it is seen
  always @(negedge clk_i) begin
    if (bus_ack && last_req) units++;
    if (bus_req && !last_req) rises++;
    last_req = bus_req;
    bus_ack  = bus_req | ack_force;
    hi_ack   = hi_req;
  end

  typedef struct packed {
    logic [1:0] src;
    logic [1:0] det;
    logic       burst;
    logic       ie;
    logic       pr;
    logic       idle;
    logic [3:0] pulses;
    logic [7:0] cnt;
    logic [7:0] units;
    logic [7:0] rises;
    logic       te;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'd3, 8'd3, 8'd3, 1'b1},
    '{2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 8'd4, 8'd4, 8'd1, 1'b1},
    '{2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'd2, 8'd2, 8'd2, 1'b1},
    '{2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 8'd2, 8'd2, 8'd1, 1'b1},
    '{2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'd3, 8'd0, 8'd0, 1'b0},
    '{2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2, 8'd3, 8'd2, 8'd2, 1'b0},
    '{2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5, 8'd3, 8'd3, 8'd3, 1'b1},
    '{2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'd2, 8'd0, 8'd0, 1'b0},
    '{2'd1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 8'd3, 8'd3, 8'd3, 1'b1},
    '{2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 8'd2, 8'd0, 8'd0, 1'b0},
    '{2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 8'd2, 8'd2, 8'd1, 1'b1},
    '{2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd1, 8'd3, 8'd3, 8'd1, 1'b1}
  };

  function automatic logic [DW-1:0] ctrl_word(logic en, logic ie, logic burst,
                                              logic [1:0] det, logic [1:0] src, logic keep);
    ctrl_word = DW'({keep, src, det, burst, ie, en});
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(logic a, logic [DW-1:0] d);
    @(negedge clk_i);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_i);
    wr_en = 1'b0;
  endtask

  task automatic clr_counts();
    @(posedge clk_i);
    units = 0; rises = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk_i);
    // R1 reset state
    check(cnt == 0, "R1 cnt", int'(cnt), 0);
    check(te == 0 && irq == 0, "R1 te/irq", int'({te, irq}), 0);
    check(bus_req == 0, "R1 bus_req", int'(bus_req), 0);

    // R2 count load, R8 auto with enable 0
    wr(1'b1, DW'(3));
    check(cnt == 3, "R2 count load", int'(cnt), 3);
    clr_counts();
    wr(1'b0, ctrl_word(1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 1'b1));
    repeat (10) @(negedge clk_i);
    check(rises == 0 && cnt == 3, "R8 disabled auto", rises, 0);

    // R8 auto enabled with count 0
    do_reset();
    clr_counts();
    wr(1'b0, ctrl_word(1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 1'b1));
    repeat (10) @(negedge clk_i);
    check(rises == 0 && te == 0, "R8 zero count", rises, 0);

    // table: R3 R4 R5 R6 R7 R8 R10 R11
    for (int v = 0; v < NV; v++) begin
      do_reset();
      dreq = VECS[v].idle;
      periph_req = VECS[v].pr;
      wr(1'b1, DW'(VECS[v].cnt));
      clr_counts();
      wr(1'b0, ctrl_word(1'b1, VECS[v].ie, VECS[v].burst, VECS[v].det, VECS[v].src, 1'b1));
      for (int c = 0; c < 80; c++) begin
        @(negedge clk_i);
        if ((c % 12 == 4) && (c / 12 < int'(VECS[v].pulses))) dreq = ~VECS[v].idle;
        else if (c % 12 == 6) dreq = VECS[v].idle;
      end
      check(units == int'(VECS[v].units), $sformatf("R3/R8 units vec%0d", v), units, int'(VECS[v].units));
      check(rises == int'(VECS[v].rises), $sformatf("R5/R6/R7 rises vec%0d", v), rises, int'(VECS[v].rises));
      check(int'(cnt) == int'(VECS[v].cnt) - int'(VECS[v].units), $sformatf("R9 cnt vec%0d", v),
            int'(cnt), int'(VECS[v].cnt) - int'(VECS[v].units));
      check(te == VECS[v].te, $sformatf("R10 te vec%0d", v), int'(te), int'(VECS[v].te));
      check(irq == (VECS[v].te & VECS[v].ie), $sformatf("R11 irq vec%0d", v), int'(irq),
            int'(VECS[v].te & VECS[v].ie));
    end

    // R10 / R11 keep and clear of the end flag (last vector left te=1, ie=1)
    wr(1'b0, ctrl_word(1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1));
    check(te == 1, "R10 keep bit", int'(te), 1);
    check(irq == 0, "R11 ie off", int'(irq), 0);
    wr(1'b0, ctrl_word(1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1));
    check(irq == 1, "R11 ie on later", int'(irq), 1);
    wr(1'b0, ctrl_word(1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0));
    check(te == 0 && irq == 0, "R10 clear", int'({te, irq}), 0);

    // R9 stray acknowledge while idle
    do_reset();
    periph_req = 1'b0;
    wr(1'b1, DW'(4));
    clr_counts();
    wr(1'b0, ctrl_word(1'b1, 1'b0, 1'b0, 2'd0, 2'd1, 1'b1));
    ack_force = 1'b1;
    repeat (10) @(negedge clk_i);
    ack_force = 1'b0;
    repeat (2) @(negedge clk_i);
    check(cnt == 4 && units == 0, "R9 stray ack", int'(cnt), 4);

    // R4 high channel ignores detection select (fixed active low)
    do_reset();
    dreq = 1'b0;
    wr(1'b1, DW'(2));
    wr(1'b0, ctrl_word(1'b1, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1));
    repeat (30) @(negedge clk_i);
    check(cnt == 2, "R3 low channel level high idle", int'(cnt), 2);
    check(hi_cnt == 0 && hi_te == 1, "R4 high channel fixed low", int'(hi_cnt), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule